// File: doc/BRIEF.md
# Buffered Countdown Timer Bank

The block holds five independent down-counting timer channels that share one control word. Each channel has a count buffer that software writes ahead of time and a live counter that reads back its current value. Channels 0 to 3 also have a compare buffer, which is stored and read back here and used by output logic outside the block. Channel 4 has none. A rising edge on a channel's manual-update bit copies its count buffer into the live counter. A rising edge on its start bit sets it running, and a falling edge stops it.

While a channel runs, every pulse on its tick input decrements the counter. When a tick arrives with the counter at zero, the channel pulses its expiry output for one cycle. If its auto-reload bit is set, it then reloads from the count buffer and keeps counting. If that bit is clear, it stops and the block clears the start bit in the control word.

The register port has a single write path and a separate combinational read path. The tick inputs come from an external prescaler, one strobe per channel.

Top module: `cd_timer_bank`

## Requirements
- R1: After reset the control word, every buffer and every live counter read 0, and no expiry output is high.
- R2: Register addresses are: control word at 0x00, count buffer of channel n at 0x08+n, compare buffer of channel n at 0x10+n, live counter of channel n at 0x18+n. Writes to a live counter, to compare buffer 0x14 of channel 4, or to any unmapped address change nothing. Reads of those unmapped or absent registers return 0.
- R3: Control fields for channel 0 are start bit 0, manual update bit 1, output invert bit 2 and auto-reload bit 3. Channels 1 to 3 use the same order starting at bit 4+4n. Channel 4 has start at bit 20, manual update at bit 21 and auto-reload at bit 22.
- R4: Writing the control word so that a channel's manual-update bit goes from 0 to 1 loads that channel's count buffer into its live counter. Rewriting the bit while it is already 1 loads nothing.
- R5: A 0-to-1 change of a start bit makes the channel count. A 1-to-0 change stops it, and the counter then holds its value across ticks.
- R6: A running channel's counter decrements by one on each tick that arrives while it is non-zero.
- R7: A tick that arrives at a running channel whose counter is 0 drives that channel's expiry bit high for exactly the following cycle.
- R8: At expiry with auto-reload set, the counter takes the count buffer's value and the channel keeps running.
- R9: At expiry with auto-reload clear, the channel stops, its start bit reads back 0, and later ticks leave the counter at 0.
- R10: When one control write raises both the manual-update and the start bit of a channel, the load happens first, so the first tick decrements the loaded value.
- R11: Ticks that arrive in the same cycle as a control-word write are ignored by every channel.
- R12: Control bits 4 to 7 and bits 23 and above are not stored and read back as 0. The full stored mask is 0x7FFF0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | BUS_W (32) | Write data |
| rd_addr_i | input | 5 | Read address |
| rd_data_o | output | BUS_W (32) | Read data, combinational from rd_addr_i |
| tick_i | input | 5 | Per-channel count strobe |
| expire_o | output | 5 | Per-channel one-cycle expiry pulse |

## Verification
The directed part of the test covers the cases that separate the rules from one another:
- A repeated manual-update write with a changed buffer shows that loading needs an edge and not a level.
- A write that raises manual update and start together shows that the load comes first.
- An auto-reload channel and a one-shot channel run side by side. This shows the reload path apart from the hardware clear of the start bit.
- A tick during a control write, and ticks after a stop, show when the counter holds.

The test then applies long random mixes of control writes, buffer writes, stray writes and multi-channel ticks. After each cycle, every read and expiry bit is compared with a model of the rules. This exposes interactions between channels and same-cycle conflicts.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned NUM_CH = 5;
  localparam int unsigned CTRL_W = 23;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [1:0] {
    K_CTRL   = 2'd0,
    K_CNTBUF = 2'd1,
    K_CMPBUF = 2'd2,
    K_LIVE   = 2'd3
  } reg_kind_e;

  function automatic int unsigned ch_base(int unsigned n);
    return (n == 0) ? 0 : 4 + 4 * n;
  endfunction

  // last channel has no invert bit, so its reload sits one lower
  function automatic int unsigned ar_pos(int unsigned n);
    return (n == NUM_CH - 1) ? ch_base(n) + 2 : ch_base(n) + 3;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int unsigned n = 0; n < NUM_CH; n++) begin
      m[ch_base(n)]     = 1'b1;
      m[ch_base(n) + 1] = 1'b1;
      m[ar_pos(n)]      = 1'b1;
      if (n < NUM_CH - 1) m[ch_base(n) + 2] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [CTRL_W-1:0] CTRL_MASK = ctrl_mask();
endpackage

// File: rtl/cdt_ctrl_reg.sv
module cdt_ctrl_reg
  import cdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] clr_start_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [NUM_CH-1:0] load_o,
  output logic [NUM_CH-1:0] run_o,
  output logic [NUM_CH-1:0] reload_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    for (int unsigned n = 0; n < NUM_CH; n++) clr_vec[ch_base(n)] = clr_start_i[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= wdata_i & CTRL_MASK;
    else           ctrl_q <= ctrl_q & ~clr_vec;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_fld
    localparam int unsigned SB = ch_base(g);
    localparam int unsigned UB = SB + 1;
    localparam int unsigned AB = ar_pos(g);
    assign load_o[g]   = wr_i & wdata_i[UB] & ~ctrl_q[UB];
    assign run_o[g]    = ctrl_q[SB];
    assign reload_o[g] = ctrl_q[AB];

    // R9: hardware stop clears the start bit
    a_r9_start_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_start_i[g] && !wr_i) |=> !run_o[g]);
    // R5: without a write or expiry, the run state holds
    a_r5_run_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_i && !clr_start_i[g]) |=> $stable(run_o[g]));
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/cdt_buf_file.sv
module cdt_buf_file
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  reg_kind_e                     kind_i,
  input  logic [2:0]                    ch_i,
  input  logic [CNT_W-1:0]              wdata_i,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cnt_buf_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cmp_buf_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_buf
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else if (wr_i && kind_i == K_CNTBUF && ch_i == 3'(g)) cnt_q <= wdata_i;
    end
    assign cnt_buf_o[g] = cnt_q;

    if (g < NUM_CH - 1) begin : g_cmp
      logic [CNT_W-1:0] cmp_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cmp_q <= '0;
        else if (wr_i && kind_i == K_CMPBUF && ch_i == 3'(g)) cmp_q <= wdata_i;
      end
      assign cmp_buf_o[g] = cmp_q;
    end else begin : g_nocmp
      assign cmp_buf_o[g] = '0;
    end
  end
endmodule

// File: rtl/cdt_channel.sv
module cdt_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             load_i,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             clr_start_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             expire_q;
  logic             hit, at_zero, fire;

  assign hit         = run_i & tick_i & ~hold_i;
  assign at_zero     = (cnt_q == '0);
  assign fire        = hit & at_zero;
  assign clr_start_o = fire & ~reload_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                  cnt_d = buf_i;
    else if (hit && !at_zero)    cnt_d = cnt_q - 1'b1;
    else if (fire && reload_i)   cnt_d = buf_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      expire_q <= fire;
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = expire_q;

  // R4: manual-update edge loads the buffer
  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(buf_i));
  // R6: one decrement per accepted tick
  a_r6_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !hold_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R7: expiry only follows a tick at zero while running
  a_r7_expire_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> $past(run_i && tick_i && cnt_q == '0));
  // R8: auto-reload takes the buffer value
  a_r8_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && $past(reload_i)) |-> cnt_q == $past(buf_i));
  // R5: stopped channel holds its count
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q));
  // R11: ticks during control writes are dropped
  a_r11_hold_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !load_i) |=> $stable(cnt_q) && !expire_o);
endmodule

// File: rtl/cd_timer_bank.sv
module cd_timer_bank
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  localparam int unsigned BUS_W = (CNT_W > CTRL_W) ? CNT_W : CTRL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BUS_W-1:0]  rd_data_o,
  input  logic [NUM_CH-1:0] tick_i,
  output logic [NUM_CH-1:0] expire_o
);
  reg_kind_e                    wr_kind, rd_kind;
  logic [2:0]                   wr_ch, rd_ch;
  logic                         ctrl_wr;
  logic [CTRL_W-1:0]            ctrl;
  logic [NUM_CH-1:0]            load, run, reload, clr_start;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf, cmp_buf, live;

  assign wr_kind = reg_kind_e'(wr_addr_i[4:3]);
  assign wr_ch   = wr_addr_i[2:0];
  assign rd_kind = reg_kind_e'(rd_addr_i[4:3]);
  assign rd_ch   = rd_addr_i[2:0];
  assign ctrl_wr = wr_en_i && wr_kind == K_CTRL && wr_ch == 3'd0;

  cdt_ctrl_reg u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (ctrl_wr),
    .wdata_i     (wr_data_i[CTRL_W-1:0]),
    .clr_start_i (clr_start),
    .ctrl_o      (ctrl),
    .load_o      (load),
    .run_o       (run),
    .reload_o    (reload)
  );

  cdt_buf_file #(.CNT_W(CNT_W)) u_bufs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_en_i),
    .kind_i    (wr_kind),
    .ch_i      (wr_ch),
    .wdata_i   (wr_data_i[CNT_W-1:0]),
    .cnt_buf_o (cnt_buf),
    .cmp_buf_o (cmp_buf)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    cdt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick_i[g]),
      .hold_i      (ctrl_wr),
      .load_i      (load[g]),
      .run_i       (run[g]),
      .reload_i    (reload[g]),
      .buf_i       (cnt_buf[g]),
      .cnt_o       (live[g]),
      .expire_o    (expire_o[g]),
      .clr_start_o (clr_start[g])
    );
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_kind)
      K_CTRL: if (rd_ch == 3'd0) rd_data_o = BUS_W'(ctrl);
      K_CNTBUF: for (int unsigned n = 0; n < NUM_CH; n++)
        if (rd_ch == 3'(n)) rd_data_o = BUS_W'(cnt_buf[n]);
      K_CMPBUF: for (int unsigned n = 0; n < NUM_CH; n++)
        if (rd_ch == 3'(n)) rd_data_o = BUS_W'(cmp_buf[n]);
      K_LIVE: for (int unsigned n = 0; n < NUM_CH; n++)
        if (rd_ch == 3'(n)) rd_data_o = BUS_W'(live[n]);
      default: rd_data_o = '0;
    endcase
  end

  // R12: unmapped control bits never read back
  a_r12_ctrl_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_kind == K_CTRL) |-> (rd_data_o[CTRL_W-1:0] & ~CTRL_MASK) == '0);
  // R7: expiry pulses last one cycle unless a new tick re-arms them
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o != '0) |-> ((expire_o & ~$past(tick_i)) == '0));
endmodule

// File: tb/cd_timer_bank_bench.sv
module cd_timer_bank_bench;
  localparam int NCH = 5;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [4:0]  tick = '0;
  logic [4:0]  expire;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [22:0] m_ctrl;
  logic [31:0] m_buf [NCH];
  logic [31:0] m_cmp [NCH];
  logic [31:0] m_cnt [NCH];
  logic [4:0]  m_exp;

  localparam logic [22:0] MASK = 23'h7FFF0F;

  always #2 clk = ~clk;

  cd_timer_bank u_cd_timer_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tick_i(tick), .expire_o(expire)
  );

  function automatic int base_of(int n);
    return (n == 0) ? 0 : 4 + 4 * n;
  endfunction

  function automatic int ar_of(int n);
    return (n == 4) ? 22 : base_of(n) + 3;
  endfunction

  function automatic logic [31:0] model_read(logic [4:0] a);
    int ch = int'(a[2:0]);
    case (a[4:3])
      2'd0: return (ch == 0) ? 32'(m_ctrl) : 32'd0;
      2'd1: return (ch < NCH) ? m_buf[ch] : 32'd0;
      2'd2: return (ch < NCH - 1) ? m_cmp[ch] : 32'd0;
      default: return (ch < NCH) ? m_cnt[ch] : 32'd0;
    endcase
  endfunction

  task automatic model_update(logic wr, logic [4:0] a, logic [31:0] d, logic [4:0] tk);
    logic        wrc = wr && a == 5'd0;
    logic [22:0] nd  = d[22:0] & MASK;
    logic [22:0] clr = '0;
    for (int n = 0; n < NCH; n++) begin
      int  b  = base_of(n);
      m_exp[n] = 1'b0;
      if (wrc) begin
        if (nd[b+1] && !m_ctrl[b+1]) m_cnt[n] = m_buf[n];
      end else if (m_ctrl[b] && tk[n]) begin
        if (m_cnt[n] != 0) m_cnt[n] = m_cnt[n] - 1;
        else begin
          m_exp[n] = 1'b1;
          if (m_ctrl[ar_of(n)]) m_cnt[n] = m_buf[n];
          else clr[b] = 1'b1;
        end
      end
    end
    if (wrc) m_ctrl = nd;
    else m_ctrl = m_ctrl & ~clr;
    if (wr && a[4:3] == 2'd1 && int'(a[2:0]) < NCH) m_buf[a[2:0]] = d;
    if (wr && a[4:3] == 2'd2 && int'(a[2:0]) < NCH - 1) m_cmp[a[2:0]] = d;
  endtask

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic wr, logic [4:0] a, logic [31:0] d, logic [4:0] tk,
                      logic [4:0] ra, string tag);
    @(negedge clk);
    wr_en = wr; wr_addr = a; wr_data = d; tick = tk; rd_addr = ra;
    #1;
    check(rd_data, model_read(ra), tag, "read");
    check(32'(expire), 32'(m_exp), tag, "expire");
    model_update(wr, a, d, tk);
  endtask

  task automatic chk_lit(logic [4:0] ra, logic [31:0] exp_rd, logic [4:0] exp_ex, string tag);
    @(negedge clk);
    wr_en = 1'b0; tick = '0; rd_addr = ra;
    #1;
    check(rd_data, exp_rd, tag, "value");
    check(32'(expire), 32'(exp_ex), tag, "expire");
    model_update(1'b0, 5'd0, 32'd0, 5'd0);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, string tag);
    step(1'b1, a, d, 5'd0, 5'd0, tag);
  endtask

  task automatic tk(logic [4:0] t, string tag);
    step(1'b0, 5'd0, 32'd0, t, 5'd0, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    m_ctrl = '0; m_exp = '0;
    for (int n = 0; n < NCH; n++) begin m_buf[n] = 0; m_cmp[n] = 0; m_cnt[n] = 0; end
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_lit(5'h00, 0, 0, "R1");
    chk_lit(5'h08, 0, 0, "R1");
    chk_lit(5'h1B, 0, 0, "R1");
    // R4 edge-triggered load
    wr(5'h09, 3, "R4");
    wr(5'h00, 32'h200, "R4");
    chk_lit(5'h19, 3, 0, "R4");
    wr(5'h09, 7, "R4");
    wr(5'h00, 32'h200, "R4");
    chk_lit(5'h19, 3, 0, "R4");
    // R6/R8 auto-reload channel 1
    wr(5'h00, 32'h900, "R8");
    tk(5'b00010, "R6"); tk(5'b00010, "R6");
    chk_lit(5'h19, 1, 0, "R6");
    tk(5'b00010, "R6"); tk(5'b00010, "R7");
    chk_lit(5'h19, 7, 5'b00010, "R8");
    chk_lit(5'h00, 32'h900, 0, "R8");
    // R10 load before count, R9 one-shot stop
    wr(5'h08, 2, "R10");
    wr(5'h00, 32'h903, "R10");
    chk_lit(5'h18, 2, 0, "R10");
    tk(5'b00001, "R10");
    chk_lit(5'h18, 1, 0, "R10");
    tk(5'b00001, "R6"); tk(5'b00001, "R7");
    chk_lit(5'h18, 0, 5'b00001, "R7");
    chk_lit(5'h00, 32'h902, 0, "R9");
    tk(5'b00001, "R9");
    chk_lit(5'h18, 0, 0, "R9");
    // R5 stop holds count
    wr(5'h0A, 9, "R5");
    wr(5'h00, 32'h3902, "R5");
    tk(5'b00100, "R5");
    wr(5'h00, 32'h2902, "R5");
    tk(5'b00100, "R5"); tk(5'b00100, "R5");
    chk_lit(5'h1A, 8, 0, "R5");
    // R11 tick during control write
    step(1'b1, 5'h00, 32'h3902, 5'b00100, 5'h00, "R11");
    chk_lit(5'h1A, 8, 0, "R11");
    tk(5'b00100, "R6");
    chk_lit(5'h1A, 7, 0, "R6");
    // R2 address map
    wr(5'h14, 5, "R2");
    chk_lit(5'h14, 0, 0, "R2");
    wr(5'h10, 32'h55, "R2");
    chk_lit(5'h10, 32'h55, 0, "R2");
    wr(5'h1B, 4, "R2");
    chk_lit(5'h1B, 0, 0, "R2");
    chk_lit(5'h1F, 0, 0, "R2");
    // R3 channel 4 fields
    wr(5'h0C, 1, "R3");
    wr(5'h00, 32'h702902, "R3");
    chk_lit(5'h1C, 1, 0, "R3");
    tk(5'b10000, "R3"); tk(5'b10000, "R3");
    chk_lit(5'h00, 32'h702902, 5'b10000, "R3");
    chk_lit(5'h1C, 1, 0, "R3");
    // R12 unused bits
    wr(5'h00, 32'hFFFF_FFFF, "R12");
    chk_lit(5'h00, 32'h7FFF0F, 0, "R12");
    wr(5'h00, 0, "R12");

    // random mix, checked against the model
    for (int i = 0; i < 4000; i++) begin
      int op = int'($urandom % 8);
      logic [4:0] a = 5'($urandom);
      logic [31:0] d = $urandom % 6;
      if (op == 0) step(1'b1, 5'h00, $urandom, 5'($urandom), 5'($urandom), "R6");
      else if (op < 3) step(1'b1, a, d, 5'($urandom), 5'($urandom), "R2");
      else step(1'b0, 5'h00, 0, 5'($urandom), 5'($urandom), "R7");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule